// File: doc/BRIEF.md
# Security-Tagged Translation Cache

This block is a fully associative cache of page translations. It maps a linear page number to a physical page number. Each entry also stores two sets of access rights, one for the owning task and one for every other task. It further stores a ciphered-page flag, a certified-descriptor flag, a page-present flag, the owner task identifier and a key identifier. A lookup is answered in the same cycle. The answer gives hit, the physical page, the ciphered flag, the key identifier, a permission-fault flag for the requested access, and a fault flag for a page that is swapped out.

A page walker installs translations through the fill port. A fill for a page number that is already cached overwrites that entry. Otherwise the fill takes the lowest free slot, or the slot under a round-robin pointer when the table is full. Software can drop a single page or the whole table. The block samples the current task identifier every cycle. When it changes, every entry whose descriptor was certified is discarded and all other entries are kept. Lookups made in the cycle of the change already skip certified entries.

Top module: `sec_tlb`

## Requirements
- R1: After synchronous reset every entry is invalid, so every lookup misses.
- R2: A lookup with `lk_valid` high whose page number matches a valid entry drives `lk_hit`=1 together with that entry's physical page, ciphered flag and key identifier. A miss drives `lk_hit`, `lk_ppn`, `lk_ciph`, `lk_key`, `lk_perm_fault` and `lk_absent_fault` all to zero.
- R3: Lookup is combinational. A fill presented at a clock edge is visible to lookups from the cycle after that edge.
- R4: A fill whose page number matches a valid entry overwrites that entry, so a page number never occupies two entries.
- R5: When `cur_tid` differs from its value in the previous cycle, every entry with the certified flag set becomes invalid at the next edge, and lookups in that same cycle already ignore certified entries. Entries without the flag are kept.
- R6: Access codes are 0 = read, 1 = write, 2 = execute and 3 = reserved. Rights fields use bit 0 for read, bit 1 for write and bit 2 for execute. The owner set applies when the entry's owner equals `cur_tid`, and the other set applies otherwise. On a hit, `lk_perm_fault` is 1 when the selected bit for the access is clear, and it is always 1 for code 3.
- R7: A hit on an entry whose present flag is clear drives `lk_absent_fault`=1. This is independent of the permission result.
- R8: A fill with no matching page number goes to the lowest-index invalid entry. If none is invalid, it goes to the round-robin pointer. The pointer is 0 after reset and advances by one, wrapping, only when a valid entry is replaced this way.
- R9: `flush_lpn_valid` invalidates only the entry whose page number equals `flush_lpn`.
- R10: `flush_all` invalidates every entry. A fill in the same cycle is applied after all invalidations, so its entry stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_tid | input | TID_W | Identifier of the running task |
| lk_valid | input | 1 | Lookup request |
| lk_lpn | input | LPN_W | Lookup linear page number |
| lk_acc | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 reserved) |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page number on hit |
| lk_ciph | output | 1 | Hit page is ciphered |
| lk_key | output | KEY_W | Key identifier of the hit page |
| lk_perm_fault | output | 1 | Access not permitted for the current task |
| lk_absent_fault | output | 1 | Hit page is not present in memory |
| fill_valid | input | 1 | Install a translation |
| fill_lpn | input | LPN_W | Page number to install |
| fill_ppn | input | PPN_W | Physical page to install |
| fill_own_rights | input | 3 | Owner rights {x,w,r} |
| fill_oth_rights | input | 3 | Rights of other tasks {x,w,r} |
| fill_ciph | input | 1 | Ciphered flag |
| fill_cert | input | 1 | Certified flag |
| fill_present | input | 1 | Present flag |
| fill_owner | input | TID_W | Owner task identifier |
| fill_key | input | KEY_W | Key identifier |
| flush_all | input | 1 | Invalidate every entry |
| flush_lpn_valid | input | 1 | Invalidate one page |
| flush_lpn | input | LPN_W | Page number to invalidate |

## Verification
The checker assumes that inputs are stable for a whole cycle and that page numbers are unique among valid entries. Only the fill path can break that uniqueness, and R4 protects it. The one-hot and fill-landing properties therefore rely on fills being the sole writer. The bench keeps to this by changing every input only on the falling edge, and by driving all table changes through the fill and flush ports. It uses an eight-entry table so that every slot and every access code can be swept against a reference model after each step. The sweeps also run in the very cycle of a task change.

// File: rtl/sec_tlb_pkg.sv
package sec_tlb_pkg;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } rights_t;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    function automatic logic rights_allow(rights_t rg, acc_e acc);
        case (acc)
            ACC_READ:  return rg.r;
            ACC_WRITE: return rg.w;
            ACC_EXEC:  return rg.x;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sec_tlb_match.sv
module sec_tlb_match #(
    parameter int ENTRIES = 64,
    parameter int LPN_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0][LPN_W-1:0] tags,
    input  logic [ENTRIES-1:0]            live,
    input  logic                          en,
    input  logic [LPN_W-1:0]              key,
    output logic [ENTRIES-1:0]            vec,
    output logic                          any,
    output logic [IDX_W-1:0]              idx
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign vec[g] = en && live[g] && (tags[g] == key);
    end

    assign any = |vec;

    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (vec[i]) idx = idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/sec_tlb_victim.sv
module sec_tlb_victim #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid,
    input  logic               req,
    input  logic               match_any,
    input  logic [IDX_W-1:0]   match_idx,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (match_any)     victim = match_idx;
        else if (free_any) victim = free_idx;
        else               victim = rr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (req && !match_any && !free_any) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/sec_tlb_perm.sv
module sec_tlb_perm
    import sec_tlb_pkg::*;
#(
    parameter int TID_W = 8
) (
    input  rights_t          own,
    input  rights_t          oth,
    input  logic [TID_W-1:0] owner,
    input  logic [TID_W-1:0] tid,
    input  acc_e             acc,
    output logic             allow
);
    rights_t sel;
    assign sel   = (owner == tid) ? own : oth;
    assign allow = rights_allow(sel, acc);
endmodule

// File: rtl/sec_tlb.sv
module sec_tlb
    import sec_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int LPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int TID_W   = 8,
    parameter int KEY_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TID_W-1:0] cur_tid,
    input  logic             lk_valid,
    input  logic [LPN_W-1:0] lk_lpn,
    input  logic [1:0]       lk_acc,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_ciph,
    output logic [KEY_W-1:0] lk_key,
    output logic             lk_perm_fault,
    output logic             lk_absent_fault,
    input  logic             fill_valid,
    input  logic [LPN_W-1:0] fill_lpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [2:0]       fill_own_rights,
    input  logic [2:0]       fill_oth_rights,
    input  logic             fill_ciph,
    input  logic             fill_cert,
    input  logic             fill_present,
    input  logic [TID_W-1:0] fill_owner,
    input  logic [KEY_W-1:0] fill_key,
    input  logic             flush_all,
    input  logic             flush_lpn_valid,
    input  logic [LPN_W-1:0] flush_lpn
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [LPN_W-1:0] lpn;
        logic [PPN_W-1:0] ppn;
        rights_t          own;
        rights_t          oth;
        logic             ciph;
        logic             cert;
        logic             pres;
        logic [TID_W-1:0] owner;
        logic [KEY_W-1:0] key;
    } ent_t;

    ent_t                          ent_q [ENTRIES];
    logic [ENTRIES-1:0]            valid_q, valid_d;
    logic [ENTRIES-1:0]            cert_vec, live;
    logic [ENTRIES-1:0][LPN_W-1:0] tags;
    logic [TID_W-1:0]              tid_q;
    logic                          tid_chg;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            tags[i]     = ent_q[i].lpn;
            cert_vec[i] = ent_q[i].cert;
        end
    end

    assign tid_chg = (cur_tid != tid_q);
    assign live    = valid_q & ~(tid_chg ? cert_vec : '0);

    // lookup compare
    logic [ENTRIES-1:0] hit_vec;
    logic               hit_any;
    logic [IDX_W-1:0]   hit_idx;
    sec_tlb_match #(.ENTRIES(ENTRIES), .LPN_W(LPN_W)) u_lk (
        .tags(tags), .live(live), .en(lk_valid), .key(lk_lpn),
        .vec(hit_vec), .any(hit_any), .idx(hit_idx)
    );

    // fill compare for overwrite of an existing page
    logic [ENTRIES-1:0] fm_vec;
    logic               fm_any;
    logic [IDX_W-1:0]   fm_idx;
    sec_tlb_match #(.ENTRIES(ENTRIES), .LPN_W(LPN_W)) u_fl (
        .tags(tags), .live(valid_q), .en(fill_valid), .key(fill_lpn),
        .vec(fm_vec), .any(fm_any), .idx(fm_idx)
    );

    // single-page flush compare
    logic [ENTRIES-1:0] fx_vec;
    logic               fx_any;
    logic [IDX_W-1:0]   fx_idx;
    sec_tlb_match #(.ENTRIES(ENTRIES), .LPN_W(LPN_W)) u_fx (
        .tags(tags), .live(valid_q), .en(flush_lpn_valid), .key(flush_lpn),
        .vec(fx_vec), .any(fx_any), .idx(fx_idx)
    );

    logic [IDX_W-1:0] victim_idx;
    sec_tlb_victim #(.ENTRIES(ENTRIES)) u_vic (
        .clk(clk), .rst(rst), .valid(valid_q), .req(fill_valid),
        .match_any(fm_any), .match_idx(fm_idx), .victim(victim_idx)
    );

    ent_t sel;
    logic allow;
    assign sel = ent_q[hit_idx];

    sec_tlb_perm #(.TID_W(TID_W)) u_perm (
        .own(sel.own), .oth(sel.oth), .owner(sel.owner), .tid(cur_tid),
        .acc(acc_e'(lk_acc)), .allow(allow)
    );

    assign lk_hit          = hit_any;
    assign lk_ppn          = hit_any ? sel.ppn  : '0;
    assign lk_ciph         = hit_any && sel.ciph;
    assign lk_key          = hit_any ? sel.key  : '0;
    assign lk_perm_fault   = hit_any && !allow;
    assign lk_absent_fault = hit_any && !sel.pres;

    // invalidations first, then the fill
    always_comb begin
        valid_d = valid_q;
        if (flush_all)       valid_d = '0;
        if (tid_chg)         valid_d = valid_d & ~cert_vec;
        if (flush_lpn_valid) valid_d = valid_d & ~fx_vec;
        if (fill_valid)      valid_d[victim_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            tid_q   <= cur_tid;
        end else begin
            valid_q <= valid_d;
            tid_q   <= cur_tid;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_valid) begin
            ent_q[victim_idx] <= '{lpn:   fill_lpn,
                                   ppn:   fill_ppn,
                                   own:   rights_t'(fill_own_rights),
                                   oth:   rights_t'(fill_oth_rights),
                                   ciph:  fill_ciph,
                                   cert:  fill_cert,
                                   pres:  fill_present,
                                   owner: fill_owner,
                                   key:   fill_key};
        end
    end
endmodule

// File: rtl/sec_tlb_chk.sv
module sec_tlb_chk #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input logic               clk,
    input logic               rst,
    input logic [ENTRIES-1:0] hit_vec,
    input logic [ENTRIES-1:0] fm_vec,
    input logic               fm_any,
    input logic               fx_any,
    input logic [IDX_W-1:0]   fx_idx,
    input logic               lk_hit,
    input logic               lk_perm_fault,
    input logic               lk_absent_fault,
    input logic               fill_valid,
    input logic               fill_cert,
    input logic [IDX_W-1:0]   victim_idx,
    input logic [ENTRIES-1:0] valid_q,
    input logic [ENTRIES-1:0] cert_vec,
    input logic               tid_chg,
    input logic               flush_all,
    input logic               flush_lpn_valid
);
    p_single_hit_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec) && $onehot0(fm_vec));

    p_fill_lands_r3: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> valid_q[$past(victim_idx)]);

    p_cert_gone_r5: assert property (@(posedge clk) disable iff (rst)
        tid_chg |=> ($countones(valid_q & cert_vec) <=
                     (($past(fill_valid) && $past(fill_cert)) ? 1 : 0)));

    p_flush_all_r10: assert property (@(posedge clk) disable iff (rst)
        (flush_all && !fill_valid) |=> (valid_q == '0));

    p_miss_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (!lk_perm_fault && !lk_absent_fault));

    p_prefer_free_r8: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !fm_any && !flush_all && !tid_chg && !flush_lpn_valid && !(&valid_q))
        |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));

    p_flush_one_r9: assert property (@(posedge clk) disable iff (rst)
        (flush_lpn_valid && fx_any && !fill_valid) |=> !valid_q[$past(fx_idx)]);
endmodule

bind sec_tlb sec_tlb_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .hit_vec(hit_vec), .fm_vec(fm_vec), .fm_any(fm_any),
    .fx_any(fx_any), .fx_idx(fx_idx), .lk_hit(lk_hit),
    .lk_perm_fault(lk_perm_fault), .lk_absent_fault(lk_absent_fault),
    .fill_valid(fill_valid), .fill_cert(fill_cert), .victim_idx(victim_idx),
    .valid_q(valid_q), .cert_vec(cert_vec), .tid_chg(tid_chg),
    .flush_all(flush_all), .flush_lpn_valid(flush_lpn_valid)
);

// File: tb/tb_sec_tlb.sv
module tb_sec_tlb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 0;
    logic        rst = 1;
    logic [7:0]  cur_tid = 8'd5;
    logic        lk_valid = 0;
    logic [19:0] lk_lpn = '0;
    logic [1:0]  lk_acc = '0;
    logic        lk_hit, lk_ciph, lk_perm_fault, lk_absent_fault;
    logic [19:0] lk_ppn;
    logic [7:0]  lk_key;
    logic        fill_valid = 0;
    logic [19:0] fill_lpn = '0, fill_ppn = '0;
    logic [2:0]  fill_own_rights = '0, fill_oth_rights = '0;
    logic        fill_ciph = 0, fill_cert = 0, fill_present = 0;
    logic [7:0]  fill_owner = '0, fill_key = '0;
    logic        flush_all = 0, flush_lpn_valid = 0;
    logic [19:0] flush_lpn = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_tlb #(.ENTRIES(N)) dut (.*);

    int checks = 0;
    int fails  = 0;

    // reference model of the table
    logic        m_valid [N];
    logic [19:0] m_lpn   [N];
    logic [19:0] m_ppn   [N];
    logic [2:0]  m_own   [N];
    logic [2:0]  m_oth   [N];
    logic        m_ciph  [N];
    logic        m_cert  [N];
    logic        m_pres  [N];
    logic [7:0]  m_owner [N];
    logic [7:0]  m_key   [N];
    int          m_rr = 0;
    logic [7:0]  m_tid = 8'd5;

    function automatic int m_find(logic [19:0] lpn);
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_lpn[i] == lpn) return i;
        return -1;
    endfunction

    task automatic check_lpn(logic [19:0] lpn, logic [1:0] acc, string tag);
        logic [31:0] exp_v, act_v;
        logic [2:0]  rg;
        logic        allow;
        int          k;
        lk_valid = 1; lk_lpn = lpn; lk_acc = acc;
        #1;
        k = m_find(lpn);
        if (k < 0) exp_v = '0;
        else begin
            rg    = (m_owner[k] == m_tid) ? m_own[k] : m_oth[k];
            allow = (acc != 2'd3) && rg[acc];
            exp_v = {1'b1, m_ppn[k], m_ciph[k], m_key[k], !allow, !m_pres[k]};
        end
        act_v = {lk_hit, lk_ppn, lk_ciph, lk_key, lk_perm_fault, lk_absent_fault};
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s lpn=%h acc=%0d actual=%h expected=%h", tag, lpn, acc, act_v, exp_v);
        end
        lk_valid = 0;
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < N; i++)
            for (int a = 0; a < 4; a++)
                check_lpn(m_lpn[i], 2'(a), tag);
        check_lpn(20'hFFFFF, 2'd0, tag);
    endtask

    task automatic do_fill(logic [19:0] lpn, logic [19:0] ppn, logic [2:0] own,
                           logic [2:0] oth, logic ciph, logic cert, logic pres,
                           logic [7:0] owner, logic [7:0] key, logic with_flush);
        int v;
        @(negedge clk);
        fill_valid = 1; fill_lpn = lpn; fill_ppn = ppn;
        fill_own_rights = own; fill_oth_rights = oth; fill_ciph = ciph;
        fill_cert = cert; fill_present = pres; fill_owner = owner; fill_key = key;
        flush_all = with_flush;
        v = m_find(lpn);
        if (v < 0) begin
            for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) v = i;
            if (v < 0) begin
                v = m_rr;
                m_rr = (m_rr + 1) % N;
            end
        end
        if (with_flush) for (int i = 0; i < N; i++) m_valid[i] = 0;
        m_valid[v] = 1; m_lpn[v] = lpn; m_ppn[v] = ppn; m_own[v] = own;
        m_oth[v] = oth; m_ciph[v] = ciph; m_cert[v] = cert; m_pres[v] = pres;
        m_owner[v] = owner; m_key[v] = key;
        @(negedge clk);
        fill_valid = 0; flush_all = 0;
    endtask

    task automatic flush_one(logic [19:0] lpn);
        int k;
        @(negedge clk);
        flush_lpn_valid = 1; flush_lpn = lpn;
        k = m_find(lpn);
        if (k >= 0) m_valid[k] = 0;
        @(negedge clk);
        flush_lpn_valid = 0;
    endtask

    task automatic flush_everything();
        @(negedge clk);
        flush_all = 1;
        for (int i = 0; i < N; i++) m_valid[i] = 0;
        @(negedge clk);
        flush_all = 0;
    endtask

    task automatic set_tid(logic [7:0] t, string tag);
        @(negedge clk);
        cur_tid = t;
        if (t != m_tid)
            for (int i = 0; i < N; i++) if (m_cert[i]) m_valid[i] = 0;
        m_tid = t;
        check_all(tag);     // same cycle: certified entries already masked
        @(negedge clk);
        check_all(tag);     // after the edge: certified entries invalid
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_lpn[i] = 20'hABC00 + 20'(i); m_ppn[i] = '0;
            m_own[i] = '0; m_oth[i] = '0; m_ciph[i] = 0; m_cert[i] = 0;
            m_pres[i] = 0; m_owner[i] = '0; m_key[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: empty after reset
        check_all("R1");

        // R3/R8: eight fills land in free slots 0..7 and are visible next cycle
        for (int i = 0; i < N; i++) begin
            do_fill(20'(16 + 3*i), 20'(256 + 7*i), 3'(i), ~3'(i), i[0], 1'b0,
                    (i != 6), (i[0] ? 8'd5 : 8'd9), 8'(3*i + 1), 1'b0);
            check_lpn(20'(16 + 3*i), 2'd0, "R3");
        end
        check_all("R2");

        // R6: rights selection under several task identities
        set_tid(8'd9,  "R6");
        set_tid(8'd11, "R6");
        set_tid(8'd5,  "R6");
        check_lpn(20'd34, 2'd0, "R7");   // slot 6 not present

        // R4: overwrite of an existing page number
        do_fill(20'd25, 20'h777, 3'b111, 3'b001, 1'b1, 1'b0, 1'b1, 8'd5, 8'hEE, 1'b0);
        check_all("R4");

        // R8: full table -> round-robin from 0
        do_fill(20'h500, 20'h11, 3'b101, 3'b000, 1'b0, 1'b0, 1'b1, 8'd5, 8'h21, 1'b0);
        check_all("R8");

        // R9: single-page flush, then the free slot is preferred
        flush_one(20'd31);
        check_all("R9");
        do_fill(20'h501, 20'h12, 3'b011, 3'b010, 1'b1, 1'b0, 1'b1, 8'd9, 8'h22, 1'b0);
        check_all("R8");
        do_fill(20'h502, 20'h13, 3'b110, 3'b100, 1'b0, 1'b0, 1'b1, 8'd5, 8'h23, 1'b0);
        check_all("R8");

        // R5: certified entries dropped on task change, others kept
        do_fill(20'h600, 20'h14, 3'b111, 3'b111, 1'b1, 1'b1, 1'b1, 8'd5, 8'h24, 1'b0);
        do_fill(20'd28,  20'h15, 3'b001, 3'b001, 1'b0, 1'b1, 1'b1, 8'd5, 8'h25, 1'b0);
        check_all("R5");
        set_tid(8'd12, "R5");
        set_tid(8'd5,  "R5");

        // R10: flush-all with a simultaneous fill, then plain flush-all
        do_fill(20'h700, 20'h16, 3'b100, 3'b010, 1'b1, 1'b0, 1'b1, 8'd5, 8'h26, 1'b1);
        check_all("R10");
        flush_everything();
        check_all("R10");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule